// File: doc/BRIEF.md
# Quad SPI Command Snooper

The snooper sits beside a serial flash master and watches each byte that master sends. It tells the serializer, for the next byte, whether to drive one, two or four data lines, how many serial clocks the byte will take, and whether the byte is a dummy byte whose returned bits should be thrown away. It decodes the opcode at the start of each transfer to work out how long the address is and how many dummy bytes follow. It also decides whether the transfer widens to two or four lines, and if so whether that happens straight after the opcode or only once the address and dummy bytes are out.

The outputs are a function of registered state only. They describe the byte that the next strobe will accept, and they advance once per accepted byte. Pulling chip select idle returns the block to its opcode-watching state. Opcodes the decoder does not recognise put it into a pass-through state that stays at single width until chip select next goes idle.

Top module: `qsn_snoop`

## Requirements
- R1: After reset, and in the cycle after any cycle with `cs_idle_i` high, the block is in the opcode phase (code 0) at one line with no pending width change. `cs_idle_i` takes priority over a simultaneous byte strobe.
- R2: The outputs only change on a cycle where `byte_vld_i` is high, or after `cs_idle_i` has been high.
- R3: Address length is 4 bytes for opcodes 13, 0C, 3C, 6C, BC, EC, 12 and 34 (hex). For every other recognised opcode it is 4 bytes when `ext_addr_i` is high and 3 bytes when it is low. `ext_addr_i` is sampled only with the opcode byte.
- R4: The number of dummy bytes is 0 for 03, 13, 02, 12, A2, 32 and 34. It is 1 for 0B, 3B, 6B, 3C and 6C. It is 2 for BB, BC and 0C. It is 5 for EB and EC.
- R5: Any other opcode moves the block to the pass-through phase (code 4) at one line. It stays there, with no dummy bytes, until `cs_idle_i` rises.
- R6: Opcodes 3B, 3C and A2 switch to two lines, and 6B, 6C, 32 and 34 switch to four lines. The switch is deferred: the address and dummy bytes still go out at one line, and the first data byte goes out wide.
- R7: Opcodes BB and BC switch to two lines, and EB and EC switch to four lines, starting with the first address byte.
- R8: After a recognised opcode, the phase runs through the address phase (code 1), then the dummy phase (code 2) if any dummy bytes are due, then the data phase (code 3). The data phase holds its width until `cs_idle_i` rises.
- R9: `lanes_o` is always 1, 2 or 4. `cycles_o` equals 8 divided by `lanes_o`. `dummy_o` is high exactly while the phase is the dummy phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_idle_i | input | 1 | Chip select deasserted; restarts command tracking |
| byte_vld_i | input | 1 | A byte is sent this cycle |
| byte_i | input | BYTE_W | Value of the byte being sent |
| ext_addr_i | input | 1 | Use 4-byte addresses for opcodes without a fixed length |
| phase_o | output | 3 | Phase of the next byte: 0 opcode, 1 address, 2 dummy, 3 data, 4 pass-through |
| lanes_o | output | 3 | Data lines used for the next byte (1, 2 or 4) |
| dummy_o | output | 1 | Next byte is a dummy byte; discard what comes back |
| cycles_o | output | CYC_W | Serial clocks the next byte occupies |

## Verification
The assertions assume that a strobe only ever carries one byte per cycle. They also assume that chip select going idle restarts the command, even when a strobe arrives in the same cycle. The stimulus opens every command with a single idle cycle and then sends the opcode followed by a run of bytes. Every fourth slot in that run is left empty, and `ext_addr_i` is inverted after the opcode so that a late change is seen to have no effect. One run also raises `cs_idle_i` together with a strobe that carries a recognised opcode.

// File: rtl/qsn_pkg.sv
package qsn_pkg;
   localparam int DMY_W = 3;

   typedef enum logic [2:0] {
      PH_OPCODE = 3'd0,
      PH_ADDR   = 3'd1,
      PH_DUMMY  = 3'd2,
      PH_DATA   = 3'd3,
      PH_PASS   = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      LN_X1 = 2'd0,
      LN_X2 = 2'd1,
      LN_X4 = 2'd2
   } lane_e;

   typedef enum logic [1:0] {
      SW_NONE  = 2'd0,
      SW_LATER = 2'd1,
      SW_NOW   = 2'd2
   } switch_e;

   typedef struct packed {
      logic             known;
      logic             four_byte;
      logic [DMY_W-1:0] dummies;
      switch_e          sw;
      lane_e            target;
   } op_attr_t;
endpackage

// File: rtl/qsn_opdec.sv
module qsn_opdec
   import qsn_pkg::*;
#(
   parameter int ADDR_SHORT = 3,
   parameter int ADDR_LONG  = 4,
   parameter int LEN_W      = $clog2(ADDR_LONG + 1)
) (
   input  logic [7:0]       opcode_i,
   input  logic             ext_addr_i,
   output op_attr_t         attr_o,
   output logic [LEN_W-1:0] addr_len_o
);
   always_comb begin
      attr_o = '{known: 1'b1, four_byte: 1'b0, dummies: '0, sw: SW_NONE, target: LN_X1};
      case (opcode_i)
         8'h03: ;
         8'h13: attr_o.four_byte = 1'b1;
         8'h02: ;
         8'h12: attr_o.four_byte = 1'b1;
         8'h0B: attr_o.dummies = DMY_W'(1);
         8'h0C: begin attr_o.four_byte = 1'b1; attr_o.dummies = DMY_W'(2); end
         8'h3B: begin attr_o.dummies = DMY_W'(1); attr_o.sw = SW_LATER; attr_o.target = LN_X2; end
         8'h3C: begin attr_o.four_byte = 1'b1; attr_o.dummies = DMY_W'(1);
                      attr_o.sw = SW_LATER; attr_o.target = LN_X2; end
         8'h6B: begin attr_o.dummies = DMY_W'(1); attr_o.sw = SW_LATER; attr_o.target = LN_X4; end
         8'h6C: begin attr_o.four_byte = 1'b1; attr_o.dummies = DMY_W'(1);
                      attr_o.sw = SW_LATER; attr_o.target = LN_X4; end
         8'hA2: begin attr_o.sw = SW_LATER; attr_o.target = LN_X2; end
         8'h32: begin attr_o.sw = SW_LATER; attr_o.target = LN_X4; end
         8'h34: begin attr_o.four_byte = 1'b1; attr_o.sw = SW_LATER; attr_o.target = LN_X4; end
         8'hBB: begin attr_o.dummies = DMY_W'(2); attr_o.sw = SW_NOW; attr_o.target = LN_X2; end
         8'hBC: begin attr_o.four_byte = 1'b1; attr_o.dummies = DMY_W'(2);
                      attr_o.sw = SW_NOW; attr_o.target = LN_X2; end
         8'hEB: begin attr_o.dummies = DMY_W'(5); attr_o.sw = SW_NOW; attr_o.target = LN_X4; end
         8'hEC: begin attr_o.four_byte = 1'b1; attr_o.dummies = DMY_W'(5);
                      attr_o.sw = SW_NOW; attr_o.target = LN_X4; end
         default: attr_o.known = 1'b0;
      endcase
   end

   assign addr_len_o = (attr_o.four_byte || ext_addr_i) ? LEN_W'(ADDR_LONG) : LEN_W'(ADDR_SHORT);
endmodule

// File: rtl/qsn_lanes.sv
module qsn_lanes
   import qsn_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic             now_i,
   input  logic             arm_i,
   input  lane_e            tgt_i,
   input  logic [CNT_W-1:0] arm_cnt_i,
   output lane_e            lane_o
);
   lane_e            lane_q, next_q;
   logic [CNT_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= LN_X1;
         next_q <= LN_X1;
         pend_q <= '0;
      end else if (clear_i) begin
         lane_q <= LN_X1;
         next_q <= LN_X1;
         pend_q <= '0;
      end else if (step_i) begin
         if (now_i) begin
            lane_q <= tgt_i;
         end else if (pend_q != '0) begin
            pend_q <= pend_q - CNT_W'(1);
            if (pend_q == CNT_W'(1)) lane_q <= next_q;
         end
         if (arm_i) begin
            pend_q <= arm_cnt_i;
            next_q <= tgt_i;
         end
      end
   end

   assign lane_o = lane_q;
endmodule

// File: rtl/qsn_snoop.sv
module qsn_snoop
   import qsn_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int ADDR_SHORT = 3,
   parameter int ADDR_LONG  = 4,
   parameter int LEN_W      = $clog2(ADDR_LONG + 1),
   parameter int CYC_W      = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              ext_addr_i,
   output logic [2:0]        phase_o,
   output logic [2:0]        lanes_o,
   output logic              dummy_o,
   output logic [CYC_W-1:0]  cycles_o
);
   localparam int CNT_W = $clog2(ADDR_LONG + (1 << DMY_W));

   if (BYTE_W < 8 || (BYTE_W % 4) != 0) begin : g_bad_byte
      $error("qsn_snoop: BYTE_W must be at least 8 and a multiple of 4");
   end
   if (ADDR_SHORT < 1 || ADDR_LONG < ADDR_SHORT) begin : g_bad_addr
      $error("qsn_snoop: need 1 <= ADDR_SHORT <= ADDR_LONG");
   end

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DMY_W-1:0] dmy_q;
   op_attr_t         attr;
   logic [LEN_W-1:0] addr_len;
   lane_e            lane;
   logic             take, at_opcode;

   qsn_opdec #(.ADDR_SHORT(ADDR_SHORT), .ADDR_LONG(ADDR_LONG), .LEN_W(LEN_W)) u_dec (
      .opcode_i  (byte_i[7:0]),
      .ext_addr_i(ext_addr_i),
      .attr_o    (attr),
      .addr_len_o(addr_len)
   );

   assign take      = byte_vld_i && !cs_idle_i;
   assign at_opcode = take && (phase_q == PH_OPCODE) && attr.known;

   qsn_lanes #(.CNT_W(CNT_W)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (cs_idle_i),
      .step_i   (take),
      .now_i    (at_opcode && attr.sw == SW_NOW),
      .arm_i    (at_opcode && attr.sw == SW_LATER),
      .tgt_i    (attr.target),
      .arm_cnt_i(CNT_W'(addr_len) + CNT_W'(attr.dummies)),
      .lane_o   (lane)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OPCODE;
         cnt_q   <= '0;
         dmy_q   <= '0;
      end else if (cs_idle_i) begin
         phase_q <= PH_OPCODE;
         cnt_q   <= '0;
         dmy_q   <= '0;
      end else if (byte_vld_i) begin
         case (phase_q)
            PH_OPCODE: begin
               if (attr.known) begin
                  phase_q <= PH_ADDR;
                  cnt_q   <= CNT_W'(addr_len);
                  dmy_q   <= attr.dummies;
               end else begin
                  phase_q <= PH_PASS;
               end
            end
            PH_ADDR: begin
               if (cnt_q == CNT_W'(1)) begin
                  phase_q <= (dmy_q == '0) ? PH_DATA : PH_DUMMY;
                  cnt_q   <= CNT_W'(dmy_q);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_DUMMY: begin
               if (cnt_q == CNT_W'(1)) phase_q <= PH_DATA;
               else cnt_q <= cnt_q - CNT_W'(1);
            end
            default: ;
         endcase
      end
   end

   assign phase_o  = phase_q;
   assign lanes_o  = 3'b001 << lane;
   assign dummy_o  = (phase_q == PH_DUMMY);
   assign cycles_o = CYC_W'(BYTE_W) >> lane;
endmodule

// File: rtl/qsn_snoop_chk.sv
module qsn_snoop_chk
   import qsn_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CYC_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_idle_i,
   input logic             byte_vld_i,
   input logic [2:0]       phase_o,
   input logic [2:0]       lanes_o,
   input logic [CYC_W-1:0] cycles_o
);
   assert_idle_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle_i |=> (phase_o == PH_OPCODE && lanes_o == 3'd1));

   assert_hold_without_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld_i && !cs_idle_i) |=> ($stable(phase_o) && $stable(lanes_o)));

   assert_pass_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_PASS && !cs_idle_i) |=> (phase_o == PH_PASS && lanes_o == 3'd1));

   assert_data_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_DATA && !cs_idle_i) |=> (phase_o == PH_DATA && $stable(lanes_o)));

   assert_opcode_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_OPCODE && byte_vld_i && !cs_idle_i)
         |=> (phase_o == PH_ADDR || phase_o == PH_PASS));

   assert_dummy_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_DUMMY && byte_vld_i && !cs_idle_i)
         |=> (phase_o == PH_DUMMY || phase_o == PH_DATA));

   assert_lane_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(lanes_o) == 1 && lanes_o != 3'd0
       && (32'(cycles_o) * 32'(lanes_o)) == BYTE_W));
endmodule

bind qsn_snoop qsn_snoop_chk #(.BYTE_W(BYTE_W), .CYC_W(CYC_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_idle_i (cs_idle_i),
   .byte_vld_i(byte_vld_i),
   .phase_o   (phase_o),
   .lanes_o   (lanes_o),
   .cycles_o  (cycles_o)
);

// File: tb/qsn_snoop_tb_top.sv
module qsn_snoop_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_idle = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] byte_v = 8'h00;
   logic       ext = 1'b0;
   logic [2:0] phase, lanes;
   logic       dummy;
   logic [3:0] cycles;

   int vectors = 0;
   int fails = 0;
   bit started = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   qsn_snoop dut_i (
      .clk(clk), .rst_n(rst_n), .cs_idle_i(cs_idle), .byte_vld_i(vld),
      .byte_i(byte_v), .ext_addr_i(ext), .phase_o(phase), .lanes_o(lanes),
      .dummy_o(dummy), .cycles_o(cycles)
   );

   // reference model: per-command list of upcoming (phase, lanes) pairs
   int q_ph[$];
   int q_ln[$];
   bit m_opc = 1'b1;
   int m_steady_ph = 0;
   int m_steady_ln = 1;

   // mode: 0 none, 1 deferred, 2 immediate
   function automatic void decode(input int op, input bit e, output bit known,
                                  output int alen, output int dm, output int mode,
                                  output int w);
      bit fb = 1'b0;
      known = 1'b1; dm = 0; mode = 0; w = 1;
      case (op)
         'h03, 'h02: ;
         'h13, 'h12: fb = 1'b1;
         'h0B: dm = 1;
         'h0C: begin fb = 1'b1; dm = 2; end
         'h3B: begin dm = 1; mode = 1; w = 2; end
         'h3C: begin fb = 1'b1; dm = 1; mode = 1; w = 2; end
         'h6B: begin dm = 1; mode = 1; w = 4; end
         'h6C: begin fb = 1'b1; dm = 1; mode = 1; w = 4; end
         'hA2: begin mode = 1; w = 2; end
         'h32: begin mode = 1; w = 4; end
         'h34: begin fb = 1'b1; mode = 1; w = 4; end
         'hBB: begin dm = 2; mode = 2; w = 2; end
         'hBC: begin fb = 1'b1; dm = 2; mode = 2; w = 2; end
         'hEB: begin dm = 5; mode = 2; w = 4; end
         'hEC: begin fb = 1'b1; dm = 5; mode = 2; w = 4; end
         default: known = 1'b0;
      endcase
      alen = (fb || e) ? 4 : 3;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || cs_idle) begin
         m_opc = 1'b1; q_ph.delete(); q_ln.delete();
         m_steady_ph = 0; m_steady_ln = 1;
      end else if (vld) begin
         if (m_opc) begin
            bit k; int al, dm, md, w;
            decode(int'(byte_v), ext, k, al, dm, md, w);
            m_opc = 1'b0;
            if (!k) begin
               m_steady_ph = 4; m_steady_ln = 1;
            end else begin
               for (int i = 0; i < al + dm; i++) begin
                  q_ph.push_back(i < al ? 1 : 2);
                  q_ln.push_back(md == 2 ? w : 1);
               end
               m_steady_ph = 3; m_steady_ln = w;
            end
         end else if (q_ph.size() > 0) begin
            void'(q_ph.pop_front()); void'(q_ln.pop_front());
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         int eph, eln;
         if (m_opc) begin eph = 0; eln = 1; end
         else if (q_ph.size() > 0) begin eph = q_ph[0]; eln = q_ln[0]; end
         else begin eph = m_steady_ph; eln = m_steady_ln; end
         vectors++;
         if (int'(phase) != eph) begin
            fails++; $display("FAIL %s phase actual=%0d expected=%0d", cur_req, phase, eph);
         end
         if (int'(lanes) != eln) begin
            fails++; $display("FAIL %s lanes actual=%0d expected=%0d", cur_req, lanes, eln);
         end
         if (dummy !== (eph == 2)) begin
            fails++; $display("FAIL R9 dummy actual=%0b expected=%0b", dummy, eph == 2);
         end
         if (int'(cycles) != 8 / eln) begin
            fails++; $display("FAIL R9 cycles actual=%0d expected=%0d", cycles, 8 / eln);
         end
      end
   end

   function automatic string req_of(input int op);
      case (op)
         'h3B, 'h3C, 'hA2, 'h6B, 'h6C, 'h32, 'h34: return "R6 R3 R8";
         'hBB, 'hBC, 'hEB, 'hEC: return "R7 R4 R8";
         'h03, 'h13, 'h02, 'h12, 'h0B, 'h0C: return "R3 R4 R8";
         default: return "R5";
      endcase
   endfunction

   task automatic run_cmd(input int op, input bit e, input int n);
      @(negedge clk); #1 cs_idle = 1'b1; vld = 1'b0; cur_req = "R1";
      @(negedge clk); #1 cs_idle = 1'b0; ext = e; vld = 1'b1; byte_v = 8'(op);
      cur_req = req_of(op);
      for (int i = 1; i <= n; i++) begin
         @(negedge clk); #1;
         ext = ~e; // R3: late change must not matter
         if (i % 4 == 0) vld = 1'b0; // R2: empty slot
         else begin vld = 1'b1; byte_v = 8'(i * 29 + op); end
      end
      @(negedge clk); #1 vld = 1'b0;
   endtask

   int ops[18] = '{'h03, 'h13, 'h0B, 'h0C, 'h3B, 'h3C, 'h6B, 'h6C, 'hBB,
                   'hBC, 'hEB, 'hEC, 'h02, 'h12, 'hA2, 'h32, 'h34, 'h9F};

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      started = 1'b1;
      cur_req = "R1";
      @(negedge clk); @(negedge clk);
      for (int e = 0; e < 2; e++)
         for (int k = 0; k < 18; k++)
            run_cmd(ops[k], e[0], 16);
      // R1: idle together with a strobe carrying a known opcode mid-command
      run_cmd('hEB, 1'b0, 5);
      @(negedge clk); #1 cs_idle = 1'b1; vld = 1'b1; byte_v = 8'h6B; cur_req = "R1";
      @(negedge clk); #1 cs_idle = 1'b0; vld = 1'b0;
      @(negedge clk); @(negedge clk);
      run_cmd('h6B, 1'b1, 12);
      run_cmd('h00, 1'b0, 8);
      @(negedge clk); @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule